// File: doc/BRIEF.md
# Spare Cell Remapping Controller

The controller owns a grid of six identical logic cells arranged in two rows of three. Each of three logical roles is carried by one physical cell. Cells are numbered row-major, so cell index = row*3 + column. After reset the top row carries the roles and the bottom row is held in reserve. The environment reports per-cell fault flags and, for each role, which cells still produce the output pattern that role needs. When the cell carrying a role is flagged faulty, the controller moves the role to a replacement cell. It prefers a cell that is already known to be faulty but still matches the role's pattern. If there is none, it takes the nearest untouched spare cell. Every move is recorded in a role-to-cell table.

The same table drives a steering network. It routes each role's input word to its current cell and that cell's output word back to the role's output. A move therefore takes the function, the input connection and the output connection across in one step. Faults accumulate: each new one is resolved against the table left by earlier moves. Only one move is made per clock. When no candidate exists, the role is declared lost and its output is forced to zero.

Top module: `spare_remap`

## Requirements
- R1: After reset, role r (r = 0, 1, 2) is carried by cell r. Cells 3 to 5 are spares. `done_o` and `lost_o` are zero. `cell_map_o` carries role r's cell index in bits [3r+2:3r].
- R2: For every live role, `role_dout` equals the output word of its mapped cell, and that cell's input word equals the role's input word. A cell carrying no live role receives an all-zero input word. Data follows `cell_map_o` with no lag.
- R3: A fault flag sampled high on the cell of a live role whose cell is in the active state moves the role to the spare with the smallest Manhattan distance from the failed cell. The new table and a one-cycle `done_o` pulse appear after the clock edge that follows the sampling edge. The failed cell is then never chosen as a spare again.
- R4: Distance ties are broken toward the lower row, then toward the lower column, which is the lower cell index.
- R5: Before any spare is used, a previously failed, unused cell is reused if `match_i` bit r*6+k is high, where r is the role being moved and k is the cell. Among several such cells the nearest wins, with the tie rule of R4. Match bits for spare or active cells have no effect. `match_i` is sampled on the edge that makes the move. A reuse leaves the number of spares unchanged.
- R6: Faults on several roles sampled on the same edge are serviced in ascending role index, one per clock, with back-to-back `done_o` pulses. Each move sees the table left by the previous one.
- R7: If a role has no reusable cell and no spare left, its `lost_o` bit is set and its output is held at zero. Its table entry is left unchanged, and `done_o` still pulses once.
- R8: Fault flags on spare cells, on failed cells, on reused cells, and on cells of lost roles start no move. They give no `done_o` pulse and leave the table unchanged. A spare flagged this way stays available.
- R9: No cell ever carries two live roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 6 | Per-cell fault flag, bit k for cell k |
| match_i | input | 18 | Pattern-match report, bit r*6+k: cell k matches role r |
| role_din | input | 24 | Role input words, role r at [8r+7:8r] |
| cell_dout | input | 48 | Cell output words, cell k at [8k+7:8k] |
| cell_din | output | 48 | Steered cell input words, cell k at [8k+7:8k] |
| role_dout | output | 24 | Steered role output words, role r at [8r+7:8r] |
| cell_map_o | output | 9 | Role-to-cell table, role r at [3r+2:3r] |
| lost_o | output | 3 | Role has no replacement left |
| done_o | output | 1 | One-cycle pulse per serviced fault |

## Verification
A fault raised in one cycle is sampled on the next rising edge. The table and `done_o` then change on the edge after that, so the bench looks for each pulse at the falling edge that follows that second edge. Simultaneous faults are expected as pulses on consecutive falling edges. Expected tables are queued by the stimulus task before the fault is raised. A monitor pops one entry per observed `done_o` and flags any pulse that arrives without a queued entry. The routed data is checked combinationally only after every pulse has been drained, because the steering carries no register of its own.

// File: rtl/spare_remap_pkg.sv
package spare_remap_pkg;

    typedef enum logic [1:0] {
        CS_SPARE  = 2'd0,
        CS_ACTIVE = 2'd1,
        CS_FAILED = 2'd2,
        CS_REUSED = 2'd3
    } cell_st_e;

    function automatic int grid_dist(input int a, input int b, input int cols);
        int ra, ca, rb, cb, dr, dc;
        ra = a / cols;
        ca = a % cols;
        rb = b / cols;
        cb = b % cols;
        dr = (ra > rb) ? ra - rb : rb - ra;
        dc = (ca > cb) ? ca - cb : cb - ca;
        return dr + dc;
    endfunction

endpackage

// File: rtl/spare_remap_pick.sv
module spare_remap_pick
    import spare_remap_pkg::*;
#(
    parameter int NCELL = 6,
    parameter int COLS  = 3,
    parameter int CIW   = 3
) (
    input  logic [NCELL-1:0] reuse_mask,
    input  logic [NCELL-1:0] spare_mask,
    input  logic [CIW-1:0]   origin,
    output logic             found,
    output logic             is_reuse,
    output logic [CIW-1:0]   pick
);

    // nearest set bit; scan ascending with strict compare so ties keep the lower index
    function automatic logic [CIW:0] nearest(input logic [NCELL-1:0] m, input int org);
        logic hit;
        int   best_d;
        int   best_k;
        int   d;
        hit    = 1'b0;
        best_d = 0;
        best_k = 0;
        for (int k = 0; k < NCELL; k++) begin
            d = grid_dist(k, org, COLS);
            if (m[k] && (!hit || d < best_d)) begin
                hit    = 1'b1;
                best_d = d;
                best_k = k;
            end
        end
        return {hit, CIW'(best_k)};
    endfunction

    logic [CIW:0] reuse_res;
    logic [CIW:0] spare_res;

    always_comb begin
        reuse_res = nearest(reuse_mask, int'(origin));
        spare_res = nearest(spare_mask, int'(origin));
        is_reuse  = reuse_res[CIW];
        found     = reuse_res[CIW] | spare_res[CIW];
        pick      = reuse_res[CIW] ? reuse_res[CIW-1:0] : spare_res[CIW-1:0];
    end

endmodule

// File: rtl/spare_remap_steer.sv
module spare_remap_steer #(
    parameter int NROLE = 3,
    parameter int NCELL = 6,
    parameter int DW    = 8,
    parameter int CIW   = 3
) (
    input  logic [NROLE*CIW-1:0] map_i,
    input  logic [NROLE-1:0]     live_i,
    input  logic [NROLE*DW-1:0]  role_din,
    input  logic [NCELL*DW-1:0]  cell_dout,
    output logic [NCELL*DW-1:0]  cell_din,
    output logic [NROLE*DW-1:0]  role_dout
);

    always_comb begin
        cell_din  = '0;
        role_dout = '0;
        for (int r = 0; r < NROLE; r++) begin
            int idx;
            idx = int'(map_i[r*CIW +: CIW]);
            if (live_i[r] && idx < NCELL) begin
                cell_din[idx*DW +: DW] = role_din[r*DW +: DW];
                role_dout[r*DW +: DW]  = cell_dout[idx*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/spare_remap.sv
module spare_remap
    import spare_remap_pkg::*;
#(
    parameter int ROWS  = 2,
    parameter int COLS  = 3,
    parameter int NROLE = 3,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ROWS*COLS-1:0]       fault_i,
    input  logic [NROLE*ROWS*COLS-1:0] match_i,
    input  logic [NROLE*DW-1:0]        role_din,
    input  logic [ROWS*COLS*DW-1:0]    cell_dout,
    output logic [ROWS*COLS*DW-1:0]    cell_din,
    output logic [NROLE*DW-1:0]        role_dout,
    output logic [NROLE*$clog2(ROWS*COLS)-1:0] cell_map_o,
    output logic [NROLE-1:0]           lost_o,
    output logic                       done_o
);

    localparam int NCELL = ROWS * COLS;
    localparam int CIW   = $clog2(NCELL);
    localparam int RIW   = (NROLE > 1) ? $clog2(NROLE) : 1;

    typedef struct packed {
        cell_st_e [NCELL-1:0]          st;
        logic [NROLE-1:0][CIW-1:0]     map;
        logic [NROLE-1:0]              pend;
        logic [NROLE-1:0]              lost;
        logic                          done;
    } state_t;

    function automatic state_t init_state();
        state_t s;
        s = '0;
        for (int k = 0; k < NCELL; k++) s.st[k] = (k < NROLE) ? CS_ACTIVE : CS_SPARE;
        for (int r = 0; r < NROLE; r++) s.map[r] = CIW'(r);
        return s;
    endfunction

    state_t q, d;

    logic             sel_valid;
    logic [RIW-1:0]   sel;
    logic [CIW-1:0]   origin;
    logic [NCELL-1:0] reuse_mask;
    logic [NCELL-1:0] spare_mask;
    logic             cand_found;
    logic             cand_reuse;
    logic [CIW-1:0]   cand;

    // lowest pending role is serviced first
    always_comb begin
        sel_valid = 1'b0;
        sel       = '0;
        for (int r = NROLE - 1; r >= 0; r--) begin
            if (q.pend[r]) begin
                sel_valid = 1'b1;
                sel       = RIW'(r);
            end
        end
        origin = q.map[sel];
        for (int k = 0; k < NCELL; k++) begin
            spare_mask[k] = (q.st[k] == CS_SPARE);
            reuse_mask[k] = (q.st[k] == CS_FAILED) && match_i[int'(sel)*NCELL + k];
        end
    end

    spare_remap_pick #(
        .NCELL(NCELL),
        .COLS (COLS),
        .CIW  (CIW)
    ) u_pick (
        .reuse_mask(reuse_mask),
        .spare_mask(spare_mask),
        .origin    (origin),
        .found     (cand_found),
        .is_reuse  (cand_reuse),
        .pick      (cand)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (sel_valid) begin
            d.pend[sel]   = 1'b0;
            d.done        = 1'b1;
            d.st[origin]  = CS_FAILED;
            if (cand_found) begin
                d.map[sel]  = cand;
                d.st[cand]  = cand_reuse ? CS_REUSED : CS_ACTIVE;
            end else begin
                d.lost[sel] = 1'b1;
            end
        end
        // capture new faults; only cells still in the active state raise a move
        for (int r = 0; r < NROLE; r++) begin
            if (!q.lost[r] && !q.pend[r] && !(sel_valid && int'(sel) == r) &&
                q.st[q.map[r]] == CS_ACTIVE && fault_i[q.map[r]]) begin
                d.pend[r] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= init_state();
        else        q <= d;
    end

    spare_remap_steer #(
        .NROLE(NROLE),
        .NCELL(NCELL),
        .DW   (DW),
        .CIW  (CIW)
    ) u_steer (
        .map_i    (q.map),
        .live_i   (~q.lost),
        .role_din (role_din),
        .cell_dout(cell_dout),
        .cell_din (cell_din),
        .role_dout(role_dout)
    );

    assign cell_map_o = q.map;
    assign lost_o     = q.lost;
    assign done_o     = q.done;

    // ---------------- assertions ----------------
    a_r6_done_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(|q.pend));

    a_r8_table_moves_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (q.map != $past(q.map)) |-> q.done);

    a_r5_spares_never_grow: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(spare_mask) <= $past($countones(spare_mask)));

    for (genvar r = 0; r < NROLE; r++) begin : g_role_chk
        a_r7_lost_role_zero: assert property (@(posedge clk) disable iff (!rst_n)
            q.lost[r] |-> (role_dout[r*DW +: DW] == '0));

        a_r9_live_cell_busy: assert property (@(posedge clk) disable iff (!rst_n)
            !q.lost[r] |-> (q.st[q.map[r]] == CS_ACTIVE || q.st[q.map[r]] == CS_REUSED));

        for (genvar j = r + 1; j < NROLE; j++) begin : g_pair
            a_r9_no_shared_cell: assert property (@(posedge clk) disable iff (!rst_n)
                (!q.lost[r] && !q.lost[j]) |-> (q.map[r] != q.map[j]));
        end
    end

endmodule

// File: tb/spare_remap_tb.sv
module spare_remap_tb;

    localparam int NCELL = 6;
    localparam int NROLE = 3;
    localparam int DW    = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NCELL-1:0]       fault_i = '0;
    logic [NROLE*NCELL-1:0] match_i = '0;
    logic [NROLE*DW-1:0]    role_din = '0;
    logic [NCELL*DW-1:0]    cell_dout;
    logic [NCELL*DW-1:0]    cell_din;
    logic [NROLE*DW-1:0]    role_dout;
    logic [8:0]             cell_map_o;
    logic [2:0]             lost_o;
    logic                   done_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [8:0] map;
        logic [2:0] lost;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    // cell model: each cell adds its own offset so routing is visible
    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        assign cell_dout[k*DW +: DW] = cell_din[k*DW +: DW] + 8'(k*16 + 1);
    end

    spare_remap u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_i   (fault_i),
        .match_i   (match_i),
        .role_din  (role_din),
        .cell_dout (cell_dout),
        .cell_din  (cell_din),
        .role_dout (role_dout),
        .cell_map_o(cell_map_o),
        .lost_o    (lost_o),
        .done_o    (done_o)
    );

    function automatic logic [8:0] mk_map(input int a, input int b, input int c);
        return {3'(c), 3'(b), 3'(a)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_move(input logic [8:0] m, input logic [2:0] l, input string tag);
        exp_t e;
        e.map  = m;
        e.lost = l;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pop one expected table per done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected done", 64'(cell_map_o), 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cell_map_o == e.map, {e.tag, " table"}, 64'(cell_map_o), 64'(e.map));
                check(lost_o == e.lost, {e.tag, " lost"}, 64'(lost_o), 64'(e.lost));
            end
        end
    end

    task automatic pulse_fault(input logic [NCELL-1:0] f);
        @(negedge clk);
        fault_i = f;
        @(negedge clk);
        fault_i = '0;
    endtask

    task automatic check_data(input string tag);
        logic [NCELL-1:0] used;
        used = '0;
        for (int r = 0; r < NROLE; r++) begin
            int c;
            logic [DW-1:0] exp_o;
            c = int'(cell_map_o[r*3 +: 3]);
            if (lost_o[r]) begin
                exp_o = '0;
            end else begin
                used[c] = 1'b1;
                exp_o = role_din[r*DW +: DW] + 8'(c*16 + 1);
                check(cell_din[c*DW +: DW] == role_din[r*DW +: DW], {tag, " R2 cell input"},
                      64'(cell_din[c*DW +: DW]), 64'(role_din[r*DW +: DW]));
            end
            check(role_dout[r*DW +: DW] == exp_o, {tag, " R2 role output"},
                  64'(role_dout[r*DW +: DW]), 64'(exp_o));
        end
        for (int k = 0; k < NCELL; k++) begin
            if (!used[k])
                check(cell_din[k*DW +: DW] == '0, {tag, " R2 idle cell input"},
                      64'(cell_din[k*DW +: DW]), 64'h0);
        end
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {tag, " pulses drained"}, 64'(exp_q.size()), 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        role_din = {8'h30, 8'h20, 8'h10};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cell_map_o == mk_map(0, 1, 2), "R1 table", 64'(cell_map_o), 64'(mk_map(0, 1, 2)));
        check(lost_o == 3'b000, "R1 lost", 64'(lost_o), 64'h0);
        check(done_o == 1'b0, "R1 done", 64'(done_o), 64'h0);
        check_data("R1");

        // R3: cell1 fails, nearest spare is cell4 (distance 1)
        role_din = {8'h33, 8'h22, 8'h11};
        expect_move(mk_map(0, 4, 2), 3'b000, "R3 nearest spare");
        pulse_fault(6'b000010);
        @(negedge clk);
        check(done_o == 1'b1, "R3 done timing", 64'(done_o), 64'h1);
        drain("R3");
        check_data("R3");

        // R4: cell4 fails, spares 3 and 5 both at distance 1, lower index wins
        expect_move(mk_map(0, 3, 2), 3'b000, "R4 tie break");
        pulse_fault(6'b010000);
        drain("R4");
        check_data("R4");

        // R5 + R8: cell0 fails; failed cells 1 and 4 and spare 5 report a match for role0.
        // Spare 5 is flagged faulty at the same time, which must be ignored.
        match_i = '0;
        match_i[0*6 + 1] = 1'b1;
        match_i[0*6 + 4] = 1'b1;
        match_i[0*6 + 5] = 1'b1;
        role_din = {8'h4C, 8'h5D, 8'h6E};
        expect_move(mk_map(1, 3, 2), 3'b000, "R5 reuse nearest failed cell");
        pulse_fault(6'b100001);
        drain("R5");
        check_data("R5");

        // R6: cells 2 and 3 fail together; role1 moves first to spare 5, then role2 reuses cell0
        match_i = '0;
        match_i[2*6 + 0] = 1'b1;
        expect_move(mk_map(1, 5, 2), 3'b000, "R6 first move");
        expect_move(mk_map(1, 5, 0), 3'b000, "R6 second move");
        pulse_fault(6'b001100);
        @(negedge clk);
        check(done_o == 1'b1, "R6 first pulse", 64'(done_o), 64'h1);
        @(negedge clk);
        check(done_o == 1'b1, "R6 second pulse", 64'(done_o), 64'h1);
        drain("R6");
        check_data("R6");

        // R7: cell5 fails, no spare and no matching failed cell remains
        match_i = '0;
        role_din = {8'hA5, 8'h96, 8'h87};
        expect_move(mk_map(1, 5, 0), 3'b010, "R7 lost role");
        pulse_fault(6'b100000);
        drain("R7");
        check(role_dout[1*DW +: DW] == '0, "R7 lost output zero", 64'(role_dout[1*DW +: DW]), 64'h0);
        check_data("R7");

        // R8: faults on reused cells 0 and 1, on failed cells, and on the lost role's cell
        match_i = '1;
        pulse_fault(6'b111111);
        for (int i = 0; i < 4; i++) begin
            check(done_o == 1'b0, "R8 no pulse", 64'(done_o), 64'h0);
            @(negedge clk);
        end
        check(cell_map_o == mk_map(1, 5, 0), "R8 table held", 64'(cell_map_o), 64'(mk_map(1, 5, 0)));
        check(lost_o == 3'b010, "R8 lost held", 64'(lost_o), 64'h2);
        check_data("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule